// File: doc/BRIEF.md
# Trusted-Module FIFO Register Target (Locality Zero)

This block is the device side of a trusted-module register interface for locality zero. A host reaches it through a simple byte-addressed register bus. Each request carries an address, a read or write flag, a read length of one to four bytes and one byte of write data. The block decodes a small register window: a locality access register, a 32-bit status word, a byte-wide data FIFO window and two identification registers. The host claims the locality and then runs the usual handshake. It marks the device ready, streams a command into the FIFO, writes go, waits for data-available, drains the response and marks ready again.

Command execution is replaced by an echo engine. After a fixed latency the response equals the command bytes in the order they were written. The status word follows the buffer as it fills and drains: the burst-count field, the expect bit and the data-available bit change with the byte count. This lets a host driver or a bus model run through every handshake path without real cryptography behind the interface.

Top module: `tpm_fifo_target`

## Requirements
- R1: Addresses are BASE_ADDR plus an offset: 0x000 access, 0x018 status, 0x024 data FIFO, 0xF00 identity ({device ID in bits 31:16, vendor ID in bits 15:0}), 0xF04 revision (low byte). Any other address reads 0. Read data appears on rdData with rdValid one cycle after the request. busLen holds the byte count minus one, and bytes above that count read as 0.
- R2: After reset the access register reads 0x80. Bit 7 (register valid) always reads 1, bit 5 reads the active-locality flag, and every other bit reads 0.
- R3: Writing the access register with bit 1 set claims the locality when it is not active. Writing it with bit 5 set releases the locality when it is active. Access-register reads and writes are always accepted.
- R4: While the locality is not active, writes to any register other than the access register are dropped. Reads of those registers return 0xFF in every requested byte.
- R5: The status word reads with the family field (bits 27:26) at 1, valid (bit 7) at 1 and self-test-done (bit 2) at 1. Command-ready (bit 6) is 1 in the ready phase. Expect (bit 3) is 1 while receiving with buffer room left. Data-available (bit 4) is 1 while response bytes remain. Bits 25, 24, 5 and 1 read 0.
- R6: The burst count (status bits 23:8) equals the free buffer room while accepting a command and the unread response bytes while returning one, both capped at MAX_BURST. It is 0 while the echo engine runs.
- R7: A write to the FIFO window stores byte 0 of the write data when the device is in the ready or receive phase and the buffer holds fewer than DEPTH bytes. Otherwise the write is dropped.
- R8: Writing status bit 5 (go) while receiving starts the echo engine. Data-available is first seen by a status read made ECHO_LATENCY+1 cycles after the go write is taken. A go write in any other phase is ignored.
- R9: The response returns the command bytes in write order. After the last byte is read, data-available clears and valid stays 1.
- R10: A FIFO read while no response byte is available returns 0xFF in byte 0 and does not advance the read position.
- R11: Writing status bit 6 (command ready) in any phase other than execution empties the buffer and returns the device to the ready phase. During execution it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Request present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 24 | Byte address of the register |
| busLen | input | 2 | Read length in bytes minus one |
| busWdata | input | 8 | Write data byte |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data, unused bytes zero |

## Verification
A wrong phase or byte count shows up in the next status read, because the burst count, expect and data-available bits are all derived from that state. A wrong pointer shows up in the next FIFO read as a wrong byte or an early 0xFF. A wrong latency count changes the cycle in which data-available first reads 1, so the bench polls status every cycle after go to pin down that cycle. Dropped or accepted writes under a released locality are exposed by re-claiming the locality and reading the status word before any other access.

// File: rtl/tpm_fifo_pkg.sv
package tpm_fifo_pkg;
  typedef enum logic [1:0] {PH_READY, PH_RECV, PH_EXEC, PH_DONE} phase_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } dp_ctrl_t;

  localparam logic [23:0] OFS_ACCESS = 24'h000;
  localparam logic [23:0] OFS_STATUS = 24'h018;
  localparam logic [23:0] OFS_FIFO   = 24'h024;
  localparam logic [23:0] OFS_IDENT  = 24'hF00;
  localparam logic [23:0] OFS_REV    = 24'hF04;
endpackage

// File: rtl/tpm_fifo_buf.sv
module tpm_fifo_buf
  import tpm_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctrl_t         dpCtrl,
  input  logic [7:0]       wrByte,
  output logic [CNT_W-1:0] fifoCount,
  output logic [CNT_W-1:0] rdPtr,
  output logic [7:0]       headByte
);
  logic [7:0] mem [DEPTH];

  // storage carries no reset; only the pointers define what is valid
  always_ff @(posedge clk) begin
    if (dpCtrl.push) mem[fifoCount[PTR_W-1:0]] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoCount <= '0;
      rdPtr     <= '0;
    end else if (dpCtrl.clear) begin
      fifoCount <= '0;
      rdPtr     <= '0;
    end else begin
      if (dpCtrl.push) fifoCount <= fifoCount + 1'b1;
      if (dpCtrl.pop)  rdPtr     <= rdPtr + 1'b1;
    end
  end

  assign headByte = mem[rdPtr[PTR_W-1:0]];
endmodule

// File: rtl/tpm_fifo_ctrl.sv
module tpm_fifo_ctrl
  import tpm_fifo_pkg::*;
#(
  parameter logic [23:0] BASE_ADDR    = 24'hD40000,
  parameter int          DEPTH        = 64,
  parameter int          MAX_BURST    = 64,
  parameter int          ECHO_LATENCY = 8,
  parameter logic [15:0] VENDOR_ID    = 16'h5A17,
  parameter logic [15:0] DEVICE_ID    = 16'h0C3E,
  parameter logic [7:0]  REVISION     = 8'h21,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int LAT_W = $clog2(ECHO_LATENCY + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [23:0]      busAddr,
  input  logic [1:0]       busLen,
  input  logic [7:0]       busWdata,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] rdPtr,
  input  logic [7:0]       headByte,
  output dp_ctrl_t         dpCtrl,
  output logic             active,
  output phase_t           phase,
  output logic             rdValid,
  output logic [31:0]      rdData
);
  logic             isAcc, isSts, isFifo, isId, isRev;
  logic             rdReq, wrReq, allowed;
  logic             dataAvail, expectBit;
  logic             fifoWrOk, fifoRdOk, stsWr, readyWr, goWr;
  logic [15:0]      room, burst;
  logic [31:0]      stsWord, rawData, laneMask;
  logic [LAT_W-1:0] latCnt;

  assign isAcc  = busAddr == BASE_ADDR + OFS_ACCESS;
  assign isSts  = busAddr == BASE_ADDR + OFS_STATUS;
  assign isFifo = busAddr == BASE_ADDR + OFS_FIFO;
  assign isId   = busAddr == BASE_ADDR + OFS_IDENT;
  assign isRev  = busAddr == BASE_ADDR + OFS_REV;

  assign rdReq   = busValid && !busWrite;
  assign wrReq   = busValid && busWrite;
  assign allowed = isAcc || active;

  assign dataAvail = (phase == PH_DONE) && (rdPtr < fifoCount);
  assign expectBit = (phase == PH_RECV) && (fifoCount < CNT_W'(DEPTH));

  always_comb begin
    unique case (phase)
      PH_READY, PH_RECV: room = 16'(DEPTH) - 16'(fifoCount);
      PH_DONE:           room = 16'(fifoCount) - 16'(rdPtr);
      default:           room = '0;
    endcase
    burst = (room > 16'(MAX_BURST)) ? 16'(MAX_BURST) : room;
  end

  assign stsWord = {4'b0, 2'b01, 2'b00, burst, 1'b1, phase == PH_READY,
                    1'b0, dataAvail, expectBit, 1'b1, 2'b00};

  assign fifoWrOk = wrReq && isFifo && active &&
                    (phase == PH_READY || phase == PH_RECV) &&
                    (fifoCount < CNT_W'(DEPTH));
  assign fifoRdOk = rdReq && isFifo && active && dataAvail;
  assign stsWr    = wrReq && isSts && active;
  assign readyWr  = stsWr && busWdata[6] && (phase != PH_EXEC);
  assign goWr     = stsWr && busWdata[5] && (phase == PH_RECV);

  assign dpCtrl.push  = fifoWrOk;
  assign dpCtrl.pop   = fifoRdOk;
  assign dpCtrl.clear = readyWr;

  // locality flag
  always_ff @(posedge clk) begin
    if (!rstN) active <= 1'b0;
    else if (wrReq && isAcc) begin
      if (active && busWdata[5])       active <= 1'b0;
      else if (!active && busWdata[1]) active <= 1'b1;
    end
  end

  // handshake phase and echo latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_READY;
      latCnt <= '0;
    end else if (readyWr) begin
      phase <= PH_READY;
    end else if (goWr) begin
      phase  <= PH_EXEC;
      latCnt <= LAT_W'(ECHO_LATENCY - 1);
    end else if (phase == PH_EXEC) begin
      if (latCnt == '0) phase <= PH_DONE;
      else              latCnt <= latCnt - 1'b1;
    end else if (fifoWrOk) begin
      phase <= PH_RECV;
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++)
      laneMask[i*8 +: 8] = (2'(i) <= busLen) ? 8'hFF : 8'h00;
    if (!allowed)    rawData = 32'hFFFF_FFFF;
    else if (isAcc)  rawData = {24'b0, 1'b1, 1'b0, active, 5'b0};
    else if (isSts)  rawData = stsWord;
    else if (isFifo) rawData = {24'b0, dataAvail ? headByte : 8'hFF};
    else if (isId)   rawData = {DEVICE_ID, VENDOR_ID};
    else if (isRev)  rawData = {24'b0, REVISION};
    else             rawData = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdReq;
      if (rdReq) rdData <= rawData & laneMask;
    end
  end
endmodule

// File: rtl/tpm_fifo_target.sv
module tpm_fifo_target
  import tpm_fifo_pkg::*;
#(
  parameter logic [23:0] BASE_ADDR    = 24'hD40000,
  parameter int          DEPTH        = 64,
  parameter int          MAX_BURST    = 64,
  parameter int          ECHO_LATENCY = 8,
  parameter logic [15:0] VENDOR_ID    = 16'h5A17,
  parameter logic [15:0] DEVICE_ID    = 16'h0C3E,
  parameter logic [7:0]  REVISION     = 8'h21
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [23:0] busAddr,
  input  logic [1:0]  busLen,
  input  logic [7:0]  busWdata,
  output logic        rdValid,
  output logic [31:0] rdData
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  dp_ctrl_t         dpCtrl;
  logic             active;
  phase_t           phase;
  logic [CNT_W-1:0] fifoCount, rdPtr;
  logic [7:0]       headByte;

  tpm_fifo_ctrl #(
    .BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH), .MAX_BURST(MAX_BURST),
    .ECHO_LATENCY(ECHO_LATENCY), .VENDOR_ID(VENDOR_ID),
    .DEVICE_ID(DEVICE_ID), .REVISION(REVISION)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busLen(busLen), .busWdata(busWdata),
    .fifoCount(fifoCount), .rdPtr(rdPtr), .headByte(headByte),
    .dpCtrl(dpCtrl), .active(active), .phase(phase),
    .rdValid(rdValid), .rdData(rdData)
  );

  tpm_fifo_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .wrByte(busWdata),
    .fifoCount(fifoCount), .rdPtr(rdPtr), .headByte(headByte)
  );
endmodule

// File: rtl/tpm_fifo_target_chk.sv
module tpm_fifo_target_chk
  import tpm_fifo_pkg::*;
#(
  parameter logic [23:0] BASE_ADDR = 24'hD40000,
  parameter int          DEPTH     = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             busValid,
  input logic             busWrite,
  input logic [23:0]      busAddr,
  input logic [1:0]       busLen,
  input logic             rdValid,
  input logic [31:0]      rdData,
  input logic             active,
  input phase_t           phase,
  input logic [CNT_W-1:0] fifoCount,
  input logic [CNT_W-1:0] rdPtr
);
  logic [31:0] laneMask;
  always_comb
    for (int i = 0; i < 4; i++)
      laneMask[i*8 +: 8] = (2'(i) <= busLen) ? 8'hFF : 8'h00;

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  a_r9_rdptr_within: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr <= fifoCount);

  a_r1_read_answered: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> rdValid);

  a_r4_gated_read: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && !active && busAddr != BASE_ADDR)
      |=> rdData == $past(laneMask));

  a_r10_empty_fifo: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && active && busAddr == BASE_ADDR + OFS_FIFO &&
     !(phase == PH_DONE && rdPtr < fifoCount))
      |=> (rdData[7:0] == 8'hFF && $stable(rdPtr)));

  a_r8_exec_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_EXEC) |=> $stable(fifoCount));
endmodule

bind tpm_fifo_target tpm_fifo_target_chk #(.BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busLen(busLen), .rdValid(rdValid), .rdData(rdData),
  .active(active), .phase(phase), .fifoCount(fifoCount), .rdPtr(rdPtr)
);

// File: tb/tpm_fifo_target_test.sv
`timescale 1ns/1ps
module tpm_fifo_target_test;
  localparam logic [23:0] BASE = 24'hD40000;
  localparam logic [23:0] A_ACC = BASE + 24'h000;
  localparam logic [23:0] A_STS = BASE + 24'h018;
  localparam logic [23:0] A_FIFO = BASE + 24'h024;
  localparam logic [23:0] A_ID = BASE + 24'hF00;
  localparam logic [23:0] A_REV = BASE + 24'hF04;
  localparam int DEPTH = 64;
  localparam int LAT = 8;

  logic clk = 0, rstN = 0;
  logic busValid = 0, busWrite = 0;
  logic [23:0] busAddr = '0;
  logic [1:0] busLen = '0;
  logic [7:0] busWdata = '0;
  logic rdValid;
  logic [31:0] rdData;

  int nChecks = 0, nFail = 0;
  int mPh = 0, mCnt = 0, mRp = 0;
  logic mActive = 0;
  logic [7:0] mBuf [DEPTH];

  always #2.5 clk = ~clk;

  tpm_fifo_target #(.BASE_ADDR(BASE), .DEPTH(DEPTH), .MAX_BURST(64),
    .ECHO_LATENCY(LAT), .VENDOR_ID(16'h5A17), .DEVICE_ID(16'h0C3E),
    .REVISION(8'h21)) uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busLen(busLen), .busWdata(busWdata),
    .rdValid(rdValid), .rdData(rdData));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expSts(input int ph, input int cnt, input int rp);
    logic [31:0] s;
    int room;
    s = 32'h0400_0084;
    case (ph)
      0: begin room = DEPTH - cnt; s |= 32'h40; end
      1: begin room = DEPTH - cnt; if (cnt < DEPTH) s |= 32'h08; end
      2: room = 0;
      default: begin room = cnt - rp; if (rp < cnt) s |= 32'h10; end
    endcase
    if (room > 64) room = 64;
    s |= 32'(room) << 8;
    return s;
  endfunction

  function automatic logic [31:0] lenMask(input logic [1:0] l);
    logic [31:0] m;
    for (int i = 0; i <= 3; i++) m[i*8 +: 8] = (i <= int'(l)) ? 8'hFF : 8'h00;
    return m;
  endfunction

  task automatic busWr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d; busLen = 0;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [23:0] a, input logic [1:0] l, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a; busLen = l;
    @(negedge clk);
    busValid = 0;
    d = rdData;
  endtask

  task automatic stsCheck(input string req);
    logic [31:0] d;
    busRd(A_STS, 2'd3, d);
    chk(req, d, mActive ? expSts(mPh, mCnt, mRp) : 32'hFFFF_FFFF);
  endtask

  task automatic fifoPush(input logic [7:0] b);
    busWr(A_FIFO, b);
    if (mActive && (mPh == 0 || mPh == 1) && mCnt < DEPTH) begin
      mBuf[mCnt] = b; mCnt++; mPh = 1;
    end
  endtask

  task automatic fifoPop(input string req);
    logic [31:0] d;
    logic [7:0] e;
    busRd(A_FIFO, 2'd0, d);
    if (mActive && mPh == 3 && mRp < mCnt) begin e = mBuf[mRp]; mRp++; end
    else e = 8'hFF;
    chk(req, d, {24'b0, e});
  endtask

  task automatic cmdReady();
    busWr(A_STS, 8'h40);
    if (mActive && mPh != 2) begin mPh = 0; mCnt = 0; mRp = 0; end
  endtask

  // go write then per-cycle status polling to locate data-available
  task automatic goAndWait();
    int k;
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = A_STS; busWdata = 8'h20; busLen = 0;
    @(negedge clk);
    busWrite = 0; busLen = 2'd3;
    k = 0;
    forever begin
      @(negedge clk);
      k++;
      if (k == 1) chk("R6 burst zero while executing", {16'b0, rdData[23:8]}, 32'h0);
      if (rdData[4] || k > 40) break;
    end
    busValid = 0;
    chk("R8 echo latency", 32'(k), 32'(LAT + 1));
    mPh = 3; mRp = 0;
  endtask

  task automatic drain(input string req);
    while (mRp < mCnt) begin
      if (mRp == mCnt - 1) stsCheck("R9 data-available before last byte");
      fifoPop(req);
    end
    stsCheck("R9 valid only after last byte");
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'h1BADCAFE));
    repeat (3) @(negedge clk);
    rstN = 1;

    busRd(A_ACC, 2'd0, d);
    chk("R2 access reset value", d, 32'h80);
    stsCheck("R4 gated status read");
    busRd(A_FIFO, 2'd1, d);
    chk("R4 gated read masked by length", d, 32'h0000_FFFF);
    busWr(A_FIFO, 8'h33); // dropped: locality inactive
    busWr(A_ACC, 8'h02); mActive = 1;
    busRd(A_ACC, 2'd0, d);
    chk("R3 claim", d, 32'hA0);
    stsCheck("R4 write while inactive dropped");
    stsCheck("R5 ready status");

    busRd(A_ID, 2'd3, d);
    chk("R1 identity", d, 32'h0C3E_5A17);
    busRd(A_ID, 2'd0, d);
    chk("R1 length mask", d, 32'h17);
    busRd(A_REV, 2'd3, d);
    chk("R1 revision", d, 32'h21);
    busRd(BASE + 24'h004, 2'd3, d);
    chk("R1 unmapped reads zero", d, 32'h0);

    fifoPop("R10 empty fifo read");
    busWr(A_STS, 8'h20);
    stsCheck("R8 go ignored when ready");

    // random command rounds
    for (int r = 0; r < 16; r++) begin
      cmdReady();
      stsCheck("R11 command ready");
      n = 1 + int'($urandom % DEPTH);
      for (int i = 0; i < n; i++) begin
        fifoPush(8'($urandom));
        if ($urandom % 4 == 0) stsCheck("R6 burst while receiving");
      end
      goAndWait();
      stsCheck("R5 data-available status");
      drain("R9 echoed byte");
      fifoPop("R10 read past end");
      stsCheck("R10 pointer held");
      busRd(A_ID, 2'($urandom), d);
      chk("R1 random length read", d, 32'h0C3E_5A17 & lenMask(busLen));
    end

    // overflow: 65 writes, only 64 kept
    cmdReady();
    for (int i = 0; i < DEPTH + 1; i++) fifoPush(8'(i * 3 + 1));
    stsCheck("R7 full buffer, no expect, burst zero");
    goAndWait();
    drain("R7 stored bytes");

    // command ready during execution is ignored, afterwards clears
    cmdReady();
    fifoPush(8'hA1); fifoPush(8'hB2); fifoPush(8'hC3);
    busWr(A_STS, 8'h20); mPh = 2;
    busWr(A_STS, 8'h40);
    busWr(A_FIFO, 8'hEE);
    repeat (LAT + 4) @(negedge clk);
    mPh = 3; mRp = 0;
    stsCheck("R11 ignored during execution");
    fifoPop("R11 response intact");
    cmdReady();
    stsCheck("R11 buffer emptied");
    fifoPop("R11 nothing after clear");

    // release, then re-claim
    fifoPush(8'h5C);
    busWr(A_ACC, 8'h20); mActive = 0;
    busRd(A_ACC, 2'd0, d);
    chk("R3 release", d, 32'h80);
    busWr(A_FIFO, 8'h77);
    busWr(A_STS, 8'h40);
    busWr(A_ACC, 8'h02); mActive = 1;
    stsCheck("R4 state untouched while released");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule